// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator with Full-Duty Override

This block generates one pulse-width modulated output from a source clock. A programmable prescaler divides the source clock by (SCALE + 1) to form a tick. An 8-bit period counter advances on each tick, so one output period always spans 256 ticks. The output is high while the period counter is below the programmed duty value. A separate override bit holds the output high for the whole period, whatever the duty value says.

All settings sit in one 32-bit control word, loaded through a plain write port (a write strobe and a data word). Every write applies at once. The prescaler and the period counter restart from zero on the same clock edge, and no period boundary is awaited. Clearing the enable bit drops the output low on that edge and holds both counters at zero. The block is meant for a host that rewrites the whole word to change frequency, duty or state.

Top module: `pwmx_channel`

## Requirements
- R1: While reset is asserted, and after reset until the first write, the output is low and both counters stay at zero.
- R2: Control word layout: SCALE in bits [12:0], DUTY in bits [23:16], the full-duty override in bit 24, enable in bit 31. Bits 15:13 and 30:25 have no effect.
- R3: While enabled, the period counter advances once every SCALE+1 source clock cycles. With SCALE = 0 it advances on every cycle.
- R4: While enabled with 0 < DUTY and no override, the output waveform repeats every 256*(SCALE+1) source clock cycles.
- R5: While enabled and not overridden, the output is high exactly while the period counter is below DUTY. In each period this gives DUTY*(SCALE+1) high cycles at the start, including the case DUTY = 255.
- R6: With DUTY = 0, enable set and no override, the output stays low.
- R7: With enable set and the override bit at 1, the output is high on every cycle, whatever the value of DUTY.
- R8: A write that clears enable makes the output low from the clock edge of that write, without finishing the period in progress.
- R9: Any write restarts the prescaler and the period counter from zero on its clock edge, and the new SCALE, DUTY and override values apply from that edge.
- R10: The output is active-high. While enable is clear it stays low, even with the override bit or a nonzero DUTY.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Strobe that loads the control word on this clock edge |
| wr_data | input | 32 | Control word (layout in R2) |
| pwm_o | output | 1 | Active-high modulated output |

## Verification
The bench builds the block with its default widths: a 13-bit SCALE and an 8-bit DUTY. SCALE values from 0 to 4 keep full 256-tick periods, from 256 to 1280 cycles, within the run budget. This covers both the every-cycle tick and multi-cycle prescaling, along with the duty extremes 0 and 255. Large SCALE values only stretch the same counter behaviour, so they are left out. A per-cycle reference model, based on elapsed cycles since the last write, cross-checks every sample, including abrupt disables and writes in the middle of a period.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;
  localparam int DEF_SCALE_W = 13;
  localparam int DEF_DUTY_W  = 8;
  localparam int DEF_CTRL_W  = 32;
  localparam int DUTY_LSB    = 16;

  // Output level for a counter position: high below duty, or always when forced.
  function automatic logic high_window(input logic [DEF_DUTY_W-1:0] pos,
                                       input logic [DEF_DUTY_W-1:0] duty,
                                       input logic                  force_full);
    return force_full || (pos < duty);
  endfunction
endpackage

// File: rtl/pwmx_prescale.sv
module pwmx_prescale #(
  parameter int SCALE_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  input  logic [SCALE_W-1:0] scale,
  output logic               tick
);
  logic [SCALE_W-1:0] pre_q;

  assign tick = run && !restart && (pre_q == scale);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pre_q <= '0;
    else if (restart || !run) pre_q <= '0;
    else if (pre_q == scale) pre_q <= '0;
    else                     pre_q <= pre_q + SCALE_W'(1);
  end

  // R3: the divider count never passes the programmed divisor
  assert_pre_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= scale);
  // R9: a restart clears the divider on the next edge
  assert_pre_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> pre_q == '0);
endmodule

// File: rtl/pwmx_period.sv
module pwmx_period #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic              tick,
  output logic [DUTY_W-1:0] count
);
  logic [DUTY_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               count_q <= '0;
    else if (restart || !run) count_q <= '0;
    else if (tick)            count_q <= count_q + DUTY_W'(1);
  end

  assign count = count_q;

  // R3: one step per prescaler tick, wrapping naturally
  assert_step_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !restart) |=> count_q == $past(count_q) + DUTY_W'(1));
  // R9: restart clears the period counter
  assert_count_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> count_q == '0);
  // R1: idle and not written means held at zero
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> count_q == '0);
endmodule

// File: rtl/pwmx_shape.sv
module pwmx_shape #(
  parameter int DUTY_W = 8
) (
  input  logic              en,
  input  logic              force_full,
  input  logic [DUTY_W-1:0] duty,
  input  logic [DUTY_W-1:0] count,
  output logic              pwm
);
  always_comb begin
    if (!en) pwm = 1'b0;
    else     pwm = pwmx_pkg::high_window(count, duty, force_full);
  end
endmodule

// File: rtl/pwmx_channel.sv
module pwmx_channel #(
  parameter int SCALE_W = pwmx_pkg::DEF_SCALE_W,
  parameter int DUTY_W  = pwmx_pkg::DEF_DUTY_W,
  parameter int CTRL_W  = pwmx_pkg::DEF_CTRL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic              pwm_o
);
  localparam int DUTY_LSB = pwmx_pkg::DUTY_LSB;
  localparam int FULL_POS = DUTY_LSB + DUTY_W;
  localparam int EN_POS   = CTRL_W - 1;

  logic [SCALE_W-1:0] scale_q;
  logic [DUTY_W-1:0]  duty_q;
  logic               full_q;
  logic               en_q;

  logic               tick_w;
  logic               restart_w;
  logic [DUTY_W-1:0]  count_w;
  logic               unused_bits;

  assign unused_bits = ^{wr_data[DUTY_LSB-1:SCALE_W], wr_data[EN_POS-1:FULL_POS+1]};
  assign restart_w   = wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale_q <= '0;
      duty_q  <= '0;
      full_q  <= 1'b0;
      en_q    <= 1'b0;
    end else if (wr_en) begin
      scale_q <= wr_data[SCALE_W-1:0];
      duty_q  <= wr_data[DUTY_LSB +: DUTY_W];
      full_q  <= wr_data[FULL_POS];
      en_q    <= wr_data[EN_POS];
    end
  end

  pwmx_prescale #(.SCALE_W(SCALE_W)) u_prescale (
    .clk(clk), .rst_n(rst_n), .run(en_q), .restart(restart_w),
    .scale(scale_q), .tick(tick_w)
  );

  pwmx_period #(.DUTY_W(DUTY_W)) u_period (
    .clk(clk), .rst_n(rst_n), .run(en_q), .restart(restart_w),
    .tick(tick_w), .count(count_w)
  );

  pwmx_shape #(.DUTY_W(DUTY_W)) u_shape (
    .en(en_q), .force_full(full_q), .duty(duty_q), .count(count_w), .pwm(pwm_o)
  );

  // R8 / R10: disabled output is low
  assert_off_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !pwm_o);
  // R7: override holds the output high
  assert_full_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && full_q) |-> pwm_o);
  // R6: zero duty without override stays low
  assert_zero_duty_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !full_q && duty_q == '0) |-> !pwm_o);
  // R5: start of a period after a write is high when duty is nonzero
  assert_period_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[EN_POS] && wr_data[DUTY_LSB +: DUTY_W] != '0) |=> pwm_o);
endmodule

// File: tb/pwmx_channel_tb.sv
module pwmx_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        pwm_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwmx_channel dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .pwm_o(pwm_o));

  // Reference model: settings and cycles elapsed since the last write.
  int m_scale = 0, m_duty = 0, m_full = 0, m_en = 0, m_cyc = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_scale = 0; m_duty = 0; m_full = 0; m_en = 0; m_cyc = 0;
    end else if (wr_en) begin
      m_scale = int'(wr_data[12:0]);
      m_duty  = int'(wr_data[23:16]);
      m_full  = int'(wr_data[24]);
      m_en    = int'(wr_data[31]);
      m_cyc   = 0;
    end else begin
      m_cyc = m_cyc + 1;
    end
  end

  function automatic bit model_out();
    if (m_en == 0) return 1'b0;
    if (m_full != 0) return 1'b1;
    return ((m_cyc / (m_scale + 1)) % 256) < m_duty;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) check("R5 per-cycle model", int'(pwm_o), int'(model_out()));
  end

  function automatic logic [31:0] word(bit en, bit full, int duty, int scale, logic [8:0] junk);
    return {en, junk[5:0], full, duty[7:0], junk[8:6], scale[12:0]};
  endfunction

  // Returns at the first negedge after the write edge.
  task automatic write(logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(string tag, int s, int duty, bit full);
    int p = 256 * (s + 1);
    int highs = 0;
    int last = 0, wrapped = 0;
    for (int k = 0; k <= p; k++) begin
      if (k < p && pwm_o) highs++;
      if (k == p - 1) last = int'(pwm_o);
      if (k == p) wrapped = int'(pwm_o);
      if (k < p) @(negedge clk);
    end
    check({tag, " high count"}, highs, full ? p : duty * (s + 1));
    check({tag, " last cycle of period"}, last, int'(full));
    check({tag, " next period start R4"}, wrapped, int'(full || duty > 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 output low in reset", int'(pwm_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 output low after reset", int'(pwm_o), 0);

    write(word(1, 0, 64, 0, 9'h0));
    measure("R3 R5 scale0 duty64", 0, 64, 0);

    write(word(1, 0, 10, 2, 9'h0));
    measure("R3 R4 scale2 duty10", 2, 10, 0);

    write(word(1, 0, 0, 1, 9'h0));
    measure("R6 duty zero", 1, 0, 0);

    write(word(1, 1, 5, 1, 9'h1FF));
    measure("R7 R2 override with junk bits", 1, 5, 1);

    write(word(1, 0, 255, 0, 9'h0));
    measure("R5 duty 255", 0, 255, 0);

    write(word(1, 0, 3, 0, 9'h1FF));
    measure("R2 junk bits ignored", 0, 3, 0);

    // R8: abrupt disable mid-period
    write(word(1, 0, 200, 4, 9'h0));
    repeat (49) @(negedge clk);
    check("R8 high before disable", int'(pwm_o), 1);
    write(word(0, 0, 200, 4, 9'h0));
    check("R8 low at once after disable", int'(pwm_o), 0);
    begin
      int seen = 0;
      write(word(0, 1, 77, 0, 9'h0));
      for (int k = 0; k < 100; k++) begin
        if (pwm_o) seen++;
        @(negedge clk);
      end
      check("R10 disabled with override stays low", seen, 0);
    end

    // R9: reconfigure in the middle of a period
    write(word(1, 0, 100, 1, 9'h0));
    repeat (37) @(negedge clk);
    write(word(1, 0, 20, 0, 9'h0));
    measure("R9 mid-period rewrite", 0, 20, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule